// File: doc/BRIEF.md
# Data and ROM pointer update unit

This block keeps the two address pointers of a small 16-bit signal processor: an 8-bit data RAM pointer and an 11-bit coefficient ROM pointer. It updates both once per arithmetic instruction, when the instruction completes. The instruction supplies four things. A 2-bit code steps the low nibble of the data pointer. A 4-bit mask flips bits in the data pointer's upper field. A flag asks for the ROM pointer to step down. A 4-bit destination code can load either pointer from the internal data bus.

The data pointer's low nibble moves modulo 16, so the upper field is never carried into or borrowed from. It serves as a row select that software toggles with the mask. Four compare results on the low nibble go to the branch unit: zero, non-zero, all ones and not all ones.

Top module: `ptr_modifier`

## Requirements
- R1: When `step_en` is low, the registers holding `dp` and `rp` keep their values, whatever the other inputs are.
- R2: Step code 1 adds one to `dp[3:0]` modulo 16, so 0xF becomes 0x0 and no carry reaches `dp[7:4]`.
- R3: Step code 2 subtracts one from `dp[3:0]` modulo 16, so 0x0 becomes 0xF and no borrow reaches `dp[7:4]`.
- R4: Step code 3 clears `dp[3:0]`. Step code 0 leaves `dp[3:0]` unchanged.
- R5: After the low-nibble step, `dp[7:4]` is XORed with `hi_mask`.
- R6: Destination code 4 loads `bus_data[7:0]` into the data pointer before the step and mask of the same instruction are applied.
- R7: When `rp_dec` is set and the destination code is not 5, `rp` decrements by one, wrapping from 0 to 0x7FF.
- R8: Destination code 5 loads `bus_data[10:0]` into `rp`, and any decrement requested in that instruction is dropped.
- R9: `lo_zero`, `lo_nzero`, `lo_full` and `lo_nfull` report, in that order: `dp[3:0]`==0, `dp[3:0]`!=0, `dp[3:0]`==0xF and `dp[3:0]`!=0xF.
- R10: Reset sets `dp` and `rp` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Instruction completes this cycle |
| lo_op | input | 2 | Low-nibble step code (0 keep, 1 up, 2 down, 3 clear) |
| hi_mask | input | 4 | XOR mask for dp[7:4] |
| rp_dec | input | 1 | Request to decrement rp |
| dst_code | input | 4 | Destination code (4 = dp, 5 = rp) |
| bus_data | input | 16 | Internal data bus value |
| dp | output | 8 | Data RAM pointer |
| rp | output | 11 | ROM pointer |
| lo_zero | output | 1 | dp[3:0] == 0 |
| lo_nzero | output | 1 | dp[3:0] != 0 |
| lo_full | output | 1 | dp[3:0] == 0xF |
| lo_nfull | output | 1 | dp[3:0] != 0xF |

## Verification
The bench steps the low nibble across both wrap points, 0xF to 0x0 and 0x0 to 0xF, and checks that the upper field stays put. A design that used a full 8-bit adder would show a carry or borrow in `dp[7:4]`. It loads the data pointer and steps it in the same instruction. A design that applied the step before the load, or that ignored the load, returns the loaded value unstepped or the old pointer stepped. It requests a decrement together with a load into `rp`, and a decrement from zero. A wrong design would leave the loaded value less one, or would saturate at zero instead of reaching 0x7FF.

// File: rtl/pmod_pkg.sv
package pmod_pkg;
  parameter int DP_W  = 8;
  parameter int LO_W  = 4;
  parameter int RP_W  = 11;
  parameter int BUS_W = 16;
  parameter int DST_W = 4;
  localparam int HI_W = DP_W - LO_W;

  typedef enum logic [1:0] {
    LO_KEEP = 2'd0,
    LO_UP   = 2'd1,
    LO_DOWN = 2'd2,
    LO_CLR  = 2'd3
  } lo_op_e;

  localparam logic [DST_W-1:0] DST_DP = DST_W'(4);
  localparam logic [DST_W-1:0] DST_RP = DST_W'(5);
endpackage

// File: rtl/pmod_dp_unit.sv
module pmod_dp_unit
  import pmod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  lo_op_e           lo_op,
  input  logic [HI_W-1:0]  hi_mask,
  input  logic             load,
  input  logic [DP_W-1:0]  load_val,
  output logic [DP_W-1:0]  dp_q
);
  logic [DP_W-1:0] base, dp_d;
  logic [LO_W-1:0] lo_nx;

  always_comb begin
    base = load ? load_val : dp_q;
    unique case (lo_op)
      LO_UP:   lo_nx = base[LO_W-1:0] + LO_W'(1);
      LO_DOWN: lo_nx = base[LO_W-1:0] - LO_W'(1);
      LO_CLR:  lo_nx = '0;
      default: lo_nx = base[LO_W-1:0];
    endcase
    dp_d = {base[DP_W-1:LO_W] ^ hi_mask, lo_nx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dp_q <= '0;
    else if (step_en) dp_q <= dp_d;
  end

  a_r1_dp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(dp_q));
  a_r5_hi_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load) |=> dp_q[DP_W-1:LO_W] == $past(dp_q[DP_W-1:LO_W] ^ hi_mask));
  a_r2_lo_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && lo_op == LO_UP) |=> dp_q[LO_W-1:0] == $past(dp_q[LO_W-1:0]) + LO_W'(1));
  a_r3_lo_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && lo_op == LO_DOWN) |=> dp_q[LO_W-1:0] == $past(dp_q[LO_W-1:0]) - LO_W'(1));
endmodule

// File: rtl/pmod_rp_unit.sv
module pmod_rp_unit
  import pmod_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            dec,
  input  logic            load,
  input  logic [RP_W-1:0] load_val,
  output logic [RP_W-1:0] rp_q
);
  logic [RP_W-1:0] rp_d;

  always_comb begin
    if (load)     rp_d = load_val;
    else if (dec) rp_d = rp_q - RP_W'(1);
    else          rp_d = rp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rp_q <= '0;
    else if (step_en) rp_q <= rp_d;
  end

  a_r1_rp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(rp_q));
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && load) |=> rp_q == $past(load_val));
  a_r7_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && dec) |=> rp_q == $past(rp_q) - RP_W'(1));
endmodule

// File: rtl/pmod_lo_flags.sv
module pmod_lo_flags
  import pmod_pkg::*;
(
  input  logic [LO_W-1:0] lo,
  output logic            is_zero,
  output logic            is_nzero,
  output logic            is_full,
  output logic            is_nfull
);
  always_comb begin
    is_zero  = (lo == '0);
    is_full  = (lo == '1);
    is_nzero = |lo;
    is_nfull = ~&lo;
  end
endmodule

// File: rtl/ptr_modifier.sv
module ptr_modifier
  import pmod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [1:0]        lo_op,
  input  logic [HI_W-1:0]   hi_mask,
  input  logic              rp_dec,
  input  logic [DST_W-1:0]  dst_code,
  input  logic [BUS_W-1:0]  bus_data,
  output logic [DP_W-1:0]   dp,
  output logic [RP_W-1:0]   rp,
  output logic              lo_zero,
  output logic              lo_nzero,
  output logic              lo_full,
  output logic              lo_nfull
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic       ld_dp, ld_rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  always_comb begin
    ld_dp = (dst_code == DST_DP);
    ld_rp = (dst_code == DST_RP);
  end

  pmod_dp_unit u_dp (
    .clk(clk), .rst_n(rst_sn), .step_en(step_en),
    .lo_op(lo_op_e'(lo_op)), .hi_mask(hi_mask),
    .load(ld_dp), .load_val(bus_data[DP_W-1:0]), .dp_q(dp)
  );

  pmod_rp_unit u_rp (
    .clk(clk), .rst_n(rst_sn), .step_en(step_en), .dec(rp_dec),
    .load(ld_rp), .load_val(bus_data[RP_W-1:0]), .rp_q(rp)
  );

  pmod_lo_flags u_flags (
    .lo(dp[LO_W-1:0]), .is_zero(lo_zero), .is_nzero(lo_nzero),
    .is_full(lo_full), .is_nfull(lo_nfull)
  );

  a_r9_flag_pairs: assert property (@(posedge clk) disable iff (!rst_sn)
    (lo_zero != lo_nzero) && (lo_full != lo_nfull) && !(lo_zero && lo_full));
  a_r10_reset_zero: assert property (@(posedge clk)
    !rst_sn |-> (dp == '0 && rp == '0));
endmodule

// File: tb/sim_ptr_modifier.sv
module sim_ptr_modifier;
  logic clk = 1'b0;
  logic rst_n;
  logic step_en;
  logic [1:0] lo_op;
  logic [3:0] hi_mask;
  logic rp_dec;
  logic [3:0] dst_code;
  logic [15:0] bus_data;
  logic [7:0] dp;
  logic [10:0] rp;
  logic lo_zero, lo_nzero, lo_full, lo_nfull;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptr_modifier u0 (.*);

  typedef struct packed {
    logic        en;
    logic [1:0]  op;
    logic [3:0]  mask;
    logic        dec;
    logic [3:0]  dst;
    logic [15:0] data;
    logic [7:0]  edp;
    logic [10:0] erp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd1, 4'h0, 1'b0, 4'd0, 16'h0000, 8'h01, 11'h000}, // R2
    '{1'b1, 2'd2, 4'h0, 1'b0, 4'd0, 16'h0000, 8'h00, 11'h000}, // R3
    '{1'b1, 2'd2, 4'h0, 1'b0, 4'd0, 16'h0000, 8'h0F, 11'h000}, // R3 wrap
    '{1'b1, 2'd1, 4'h0, 1'b0, 4'd0, 16'h0000, 8'h00, 11'h000}, // R2 wrap
    '{1'b1, 2'd0, 4'h5, 1'b1, 4'd0, 16'h0000, 8'h50, 11'h7FF}, // R4 R5 R7
    '{1'b1, 2'd1, 4'h0, 1'b0, 4'd4, 16'h1237, 8'h38, 11'h7FF}, // R6
    '{1'b1, 2'd3, 4'hA, 1'b1, 4'd0, 16'h0000, 8'h90, 11'h7FE}, // R4 R5
    '{1'b1, 2'd0, 4'h0, 1'b1, 4'd5, 16'hF123, 8'h90, 11'h123}, // R8
    '{1'b0, 2'd1, 4'hF, 1'b1, 4'd4, 16'h0000, 8'h90, 11'h123}, // R1
    '{1'b1, 2'd1, 4'h1, 1'b0, 4'd4, 16'h00FF, 8'hE0, 11'h123}, // R6 R2
    '{1'b1, 2'd2, 4'h0, 1'b1, 4'd0, 16'h0000, 8'hEF, 11'h122}  // R3 R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input logic [7:0] edp);
    check(req, {28'd0, lo_zero, lo_nzero, lo_full, lo_nfull},
          {28'd0, edp[3:0] == 4'h0, edp[3:0] != 4'h0, edp[3:0] == 4'hF, edp[3:0] != 4'hF});
  endtask

  task automatic apply(input logic en, input logic [1:0] op, input logic [3:0] mask,
                       input logic dec, input logic [3:0] dst, input logic [15:0] data);
    step_en = en; lo_op = op; hi_mask = mask; rp_dec = dec; dst_code = dst; bus_data = data;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    step_en = 0; lo_op = 0; hi_mask = 0; rp_dec = 0; dst_code = 0; bus_data = 0;
    @(negedge clk);
    do_reset();
    check("R10 dp", {24'd0, dp}, 32'h0);
    check("R10 rp", {21'd0, rp}, 32'h0);
    check_flags("R9 reset", 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].en, TBL[i].op, TBL[i].mask, TBL[i].dec, TBL[i].dst, TBL[i].data);
      check($sformatf("R1-vec%0d dp", i), {24'd0, dp}, {24'd0, TBL[i].edp});
      check($sformatf("R8-vec%0d rp", i), {21'd0, rp}, {21'd0, TBL[i].erp});
      check_flags($sformatf("R9 vec%0d", i), TBL[i].edp);
    end

    // R10: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 async dp", {24'd0, dp}, 32'h0);
    check("R10 async rp", {21'd0, rp}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: decrement from zero wraps to all ones
    apply(1, 2'd0, 4'h0, 1, 4'd0, 16'h0);
    check("R7 wrap", {21'd0, rp}, 32'h7FF);
    // R6 + R3: load then decrement across nibble zero
    apply(1, 2'd2, 4'h0, 0, 4'd4, 16'hAB40);
    check("R6 load-then-step", {24'd0, dp}, 32'h4F);
    check_flags("R9 full", 8'h4F);
    // R4: clear keeps upper field
    apply(1, 2'd3, 4'h0, 0, 4'd0, 16'h0);
    check("R4 clear", {24'd0, dp}, 32'h40);
    // R8: load with decrement asked, upper bus bits dropped
    apply(1, 2'd0, 4'h0, 1, 4'd5, 16'hFFFF);
    check("R8 load no dec", {21'd0, rp}, 32'h7FF);
    // R1: many idle cycles with busy inputs
    step_en = 0; lo_op = 2'd1; hi_mask = 4'hF; rp_dec = 1; dst_code = 4'd5;
    repeat (4) @(negedge clk);
    check("R1 idle dp", {24'd0, dp}, 32'h40);
    check("R1 idle rp", {21'd0, rp}, 32'h7FF);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule